// File: doc/BRIEF.md
# Register-Mapped SPI Shift Engine

This block is an SPI host that software drives through a small 32-bit register window. To run a shift, software first loads the outgoing word into a transmit register. It then writes one command word that carries a start flag, a chip-select choice, a bit count and an end-of-transaction flag. The engine asserts the chosen active-low select and runs the bits out on MOSI in SPI mode 0, capturing MISO at the same time. When the last bit is done it drops its busy flag, which software polls, and the received word appears in a receive register.

Software can chain commands into one long transaction. A command sent without the end flag leaves its chip select low, with SCK parked low, so the next command carries on the same transfer. A command sent with the end flag releases the select when it finishes. While no transaction is open, the pins follow a static pin-level register, which comes out of reset with all selects high and SCK and MOSI low. A global enable bit must be set before any other register accepts writes.

Top module: `spi_shift_host`

## Requirements
- R1: After reset the enable register (offset 0x00, bit 0) reads 0, and the pin-level register (offset 0x08) reads 0x00070000. While enable is 0, writes to every register other than the enable register are ignored.
- R2: The clock divider is held in the control register (offset 0x04, bits [5:0]). During a shift, SCK stays high for div+1 system clocks and low for div+1 system clocks in every bit.
- R3: Bits go out in SPI mode 0. For a count of n, the bits of the transmit register (offset 0x10) from bit n-1 down to bit 0 are sent most significant first. MOSI changes only when SCK falls or when a shift starts.
- R4: MISO is sampled on each rising SCK edge. At completion, the receive register (offset 0x18) holds the n received bits right-aligned, with the last bit received in bit 0 and zeros above.
- R5: A write to the command register (offset 0x14) starts a shift. The count is in bits [5:0], and values above 32 are treated as 32. Bit 31 reads 1 from the next cycle and clears by itself exactly 2·n·(div+1) cycles after the write edge.
- R6: Command bit 28+k selects chip select k, where k is 0 to 2. The selected line, cs_n[k], is driven low for the shift. If several select bits are set, the lowest-numbered one wins.
- R7: If command bit 26 (end flag) is set, the chip select is released when the shift completes. If it is clear, the select stays low and SCK stays low until a later command ends the transaction.
- R8: While bit 31 of the command register reads 1, writes to the transmit, control and command registers are ignored.
- R9: A command with a count of 0, or with no select bit set, completes at once. Bit 31 is never seen set, no pin changes and the receive register keeps its value.
- R10: While no transaction is open, cs_n follows pin-level bits [18:16], SCK follows bit 8 and MOSI follows bit 0. While a transaction is open, any select that the pin-level register holds low stays low as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational from bus_addr) |
| sck | output | 1 | SPI serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 3 | Active-low chip selects |

## Verification
The hardest case to reach is a register write arriving in the middle of a shift. The ignore rule only shows up if the write lands while the busy bit is set and the register is read back afterwards. The driver therefore issues transmit and command writes straight after a long 24-bit command is accepted, before it starts polling. It then confirms from the serial capture and from a transmit-register read-back that neither write took effect. Chained transactions are reached by a 16-bit command without the end flag, followed by a command that ends the transaction. The bench checks that the select stays low across the gap between them.

// File: rtl/spi_shift_pkg.sv
package spi_shift_pkg;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 6;

  localparam logic [4:0] OFS_EN  = 5'h00;
  localparam logic [4:0] OFS_CTL = 5'h04;
  localparam logic [4:0] OFS_PIN = 5'h08;
  localparam logic [4:0] OFS_TXD = 5'h10;
  localparam logic [4:0] OFS_CMD = 5'h14;
  localparam logic [4:0] OFS_RXD = 5'h18;

  localparam logic [DATA_W-1:0] PIN_RESET = 32'h0007_0000;
  localparam int PIN_CS_LO = 16;
  localparam int PIN_SCK   = 8;
  localparam int PIN_MOSI  = 0;
  localparam int CMD_GO    = 31;
  localparam int CMD_CS_LO = 28;
  localparam int CMD_END   = 26;

  // counts above the word width saturate to a full word
  function automatic logic [CNT_W-1:0] clamp_count(input logic [CNT_W-1:0] raw);
    return (int'(raw) > DATA_W) ? CNT_W'(DATA_W) : raw;
  endfunction

  // first bit to send moved up to the top of the shifter
  function automatic logic [DATA_W-1:0] align_tx(input logic [DATA_W-1:0] d,
                                                 input logic [CNT_W-1:0] n);
    return d << (DATA_W - int'(n));
  endfunction

  // cycles in one full SCK period for a divider value
  function automatic int sck_period(input int div);
    return 2 * (div + 1);
  endfunction
endpackage

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] ph;

  assign tick = run && (ph == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              ph <= '0;
    else if (!run || tick)   ph <= '0;
    else                     ph <= ph + 1'b1;
  end
endmodule

// File: rtl/spi_reg_file.sv
module spi_reg_file
  import spi_shift_pkg::*;
#(
  parameter int DIV_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [4:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              busy,
  input  logic [DATA_W-1:0] rxd,
  output logic [DIV_W-1:0]  div_q,
  output logic [DATA_W-1:0] pin_q,
  output logic [DATA_W-1:0] txd_q,
  output logic              cmd_wr
);
  logic              en_q;
  logic [DATA_W-1:0] cmd_q;
  logic              wr_any, wr_live, wr_idle;

  assign wr_any  = bus_sel && bus_wr;
  assign wr_live = wr_any && en_q;
  assign wr_idle = wr_live && !busy;
  assign cmd_wr  = wr_idle && (bus_addr == OFS_CMD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      div_q <= '0;
      pin_q <= PIN_RESET;
      txd_q <= '0;
      cmd_q <= '0;
    end else begin
      if (wr_any && bus_addr == OFS_EN)   en_q  <= bus_wdata[0];
      if (wr_live && bus_addr == OFS_PIN) pin_q <= bus_wdata;
      if (wr_idle && bus_addr == OFS_CTL) div_q <= bus_wdata[DIV_W-1:0];
      if (wr_idle && bus_addr == OFS_TXD) txd_q <= bus_wdata;
      if (cmd_wr) begin
        cmd_q         <= bus_wdata;
        cmd_q[CMD_GO] <= 1'b0;
      end
    end
  end

  always_comb begin
    unique case (bus_addr)
      OFS_EN:  bus_rdata = {{(DATA_W-1){1'b0}}, en_q};
      OFS_CTL: bus_rdata = {{(DATA_W-DIV_W){1'b0}}, div_q};
      OFS_PIN: bus_rdata = pin_q;
      OFS_TXD: bus_rdata = txd_q;
      OFS_CMD: bus_rdata = {busy, cmd_q[DATA_W-2:0]};
      OFS_RXD: bus_rdata = rxd;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core
  import spi_shift_pkg::*;
#(
  parameter int NCS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [DATA_W-1:0] cmd,
  input  logic [DATA_W-1:0] txd,
  input  logic              tick,
  input  logic              miso,
  output logic              busy,
  output logic [NCS-1:0]    act_cs,
  output logic              sck_q,
  output logic              mosi_q,
  output logic [DATA_W-1:0] rxd,
  output logic              shift_done
);
  logic [DATA_W-1:0] sr, rx;
  logic [CNT_W-1:0]  left, n;
  logic [NCS-1:0]    sel, sel_low;
  logic              end_q, go;

  assign sel     = cmd[CMD_CS_LO +: NCS];
  assign sel_low = sel & (~sel + 1'b1);
  assign n       = clamp_count(cmd[CNT_W-1:0]);
  assign go      = cmd_wr && (n != '0) && (sel != '0);
  assign mosi_q  = sr[DATA_W-1];
  assign shift_done = tick && sck_q && (left == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      act_cs <= '0;
      sck_q  <= 1'b0;
      sr     <= '0;
      rx     <= '0;
      rxd    <= '0;
      left   <= '0;
      end_q  <= 1'b0;
    end else if (go) begin
      busy   <= 1'b1;
      act_cs <= sel_low;
      sck_q  <= 1'b0;
      sr     <= align_tx(txd, n);
      rx     <= '0;
      left   <= n;
      end_q  <= cmd[CMD_END];
    end else if (tick) begin
      if (!sck_q) begin
        sck_q <= 1'b1;
        rx    <= {rx[DATA_W-2:0], miso};
      end else begin
        sck_q <= 1'b0;
        left  <= left - 1'b1;
        if (shift_done) begin
          busy <= 1'b0;
          rxd  <= rx;
          if (end_q) act_cs <= '0;
        end else begin
          sr <= sr << 1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_shift_host.sv
module spi_shift_host
  import spi_shift_pkg::*;
#(
  parameter int NCS   = 3,
  parameter int DIV_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [4:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic [NCS-1:0]    cs_n
);
  logic              busy, hold, shift_done, tick, cmd_wr, sck_q, mosi_q;
  logic [NCS-1:0]    act_cs;
  logic [DIV_W-1:0]  div_q;
  logic [DATA_W-1:0] pin_q, txd_q, rxd;

  spi_reg_file #(.DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy(busy), .rxd(rxd), .div_q(div_q), .pin_q(pin_q), .txd_q(txd_q),
    .cmd_wr(cmd_wr)
  );

  spi_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(busy), .div(div_q), .tick(tick)
  );

  spi_shift_core #(.NCS(NCS)) u_core (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd(bus_wdata), .txd(txd_q),
    .tick(tick), .miso(miso), .busy(busy), .act_cs(act_cs), .sck_q(sck_q),
    .mosi_q(mosi_q), .rxd(rxd), .shift_done(shift_done)
  );

  assign hold = |act_cs;
  assign sck  = (busy || hold) ? sck_q  : pin_q[PIN_SCK];
  assign mosi = (busy || hold) ? mosi_q : pin_q[PIN_MOSI];
  assign cs_n = pin_q[PIN_CS_LO +: NCS] & ~act_cs;
endmodule

// File: rtl/spi_shift_host_chk.sv
module spi_shift_host_chk
  import spi_shift_pkg::*;
#(
  parameter int NCS = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              hold,
  input logic              shift_done,
  input logic              sck,
  input logic              mosi,
  input logic [NCS-1:0]    cs_n,
  input logic [DATA_W-1:0] pin_q,
  input logic [DATA_W-1:0] txd_q
);
  p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    shift_done |=> !busy);

  p_txd_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(txd_q));

  p_sck_parked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !busy) |-> !sck);

  p_idle_pins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !hold) |-> (sck == pin_q[PIN_SCK] && mosi == pin_q[PIN_MOSI]));

  p_one_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (&pin_q[PIN_CS_LO +: NCS]) |-> $onehot0(~cs_n));

  p_mosi_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$fell(sck)) |-> $stable(mosi));
endmodule

bind spi_shift_host spi_shift_host_chk #(.NCS(NCS)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .hold(hold),
  .shift_done(shift_done), .sck(sck), .mosi(mosi), .cs_n(cs_n),
  .pin_q(pin_q), .txd_q(txd_q)
);

// File: tb/spi_shift_host_test.sv
module spi_shift_host_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        sck, mosi, miso;
  logic [2:0]  cs_n;

  int errors = 0, checks = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  spi_shift_host uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  // serial device model: presents MSB-first data, captures MOSI on rising SCK
  logic [31:0] slv_word = '0, cap = '0;
  int slv_ptr = -1, rises = 0;
  assign miso = (slv_ptr >= 0) ? slv_word[slv_ptr] : 1'b0;
  always @(posedge sck) begin
    cap = {cap[30:0], mosi};
    slv_ptr = slv_ptr - 1;
    rises = rises + 1;
  end

  typedef struct { string req; logic [31:0] din; logic [31:0] tx; } exp_t;
  exp_t sb[$];
  event done_ev;
  logic [31:0] got_din;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  function automatic logic [31:0] low_mask(input int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 1);
  endfunction

  // monitor: pops the expected item for each finished command
  initial forever begin
    exp_t e;
    @(done_ev);
    e = sb.pop_front();
    check({e.req, " R4 din"}, got_din, e.din);
    check({e.req, " R3 mosi"}, cap, e.tx);
  end

  task automatic run_cmd(input string tag, input int cs, input bit term, input int n,
                         input logic [31:0] tx, input logic [31:0] rx, input int div,
                         input bit meddle);
    logic [31:0] v;
    int cnt = 0, hi = 0, first;
    exp_t e;
    first = (cs & 1) ? 0 : (cs & 2) ? 1 : 2;
    slv_word = rx; slv_ptr = n - 1; cap = '0; rises = 0;
    bus_write(5'h10, tx);
    e.req = tag; e.din = rx & low_mask(n); e.tx = tx & low_mask(n);
    sb.push_back(e);
    bus_write(5'h14, 32'h8000_0000 | (32'(cs) << 28) | (32'(term) << 26) | 32'(n));
    check({tag, " R6 select low"}, {29'd0, cs_n}, {29'd0, ~(3'b001 << first)});
    if (meddle) begin
      bus_write(5'h10, 32'hFFFF_FFFF);
      bus_write(5'h14, 32'h9400_0008);
      cnt = 2;
    end
    forever begin
      bus_read(5'h14, v);
      if (!v[31]) break;
      cnt++;
      if (sck) hi++;
      @(negedge clk);
    end
    bus_read(5'h18, got_din);
    -> done_ev;
    #1;
    check({tag, " R5 busy cycles"}, 32'(cnt), 32'(2 * n * (div + 1)));
    if (!meddle) check({tag, " R2 sck high cycles"}, 32'(hi), 32'(n * (div + 1)));
    check({tag, " R7 select after"}, {29'd0, cs_n},
          term ? 32'd7 : {29'd0, ~(3'b001 << first)});
    check({tag, " R7 sck low after"}, {31'd0, sck}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 / R10 reset state
    bus_read(5'h00, v); check("R1 enable reset", v, 32'd0);
    bus_read(5'h08, v); check("R1 pin reset", v, 32'h0007_0000);
    check("R10 idle pins", {29'd0, cs_n, sck, mosi} >> 2, 32'd7);
    check("R10 idle sck/mosi", {30'd0, sck, mosi}, 32'd0);
    // R1 writes ignored while disabled
    bus_write(5'h04, 32'd5);
    bus_write(5'h10, 32'h1234_5678);
    bus_read(5'h04, v); check("R1 ctl blocked", v, 32'd0);
    bus_read(5'h10, v); check("R1 txd blocked", v, 32'd0);
    bus_write(5'h00, 32'd1);
    bus_read(5'h00, v); check("R1 enable set", v, 32'd1);

    bus_write(5'h04, 32'd1);
    run_cmd("byte cs0", 1, 1'b1, 8, 32'h0000_00A5, 32'h0000_003C, 1, 1'b0);
    // chained transaction on cs1
    run_cmd("chain head", 2, 1'b0, 16, 32'h0000_1234, 32'h0000_BEEF, 1, 1'b0);
    run_cmd("chain tail", 2, 1'b1, 8, 32'h0000_0056, 32'h0000_0077, 1, 1'b0);
    // full word, fastest divider, cs2
    bus_write(5'h04, 32'd0);
    run_cmd("word cs2", 4, 1'b1, 32, 32'hDEAD_BEEF, 32'h1357_9BDF, 0, 1'b0);
    // slower divider, lowest select wins
    bus_write(5'h04, 32'd4);
    run_cmd("multi sel", 5, 1'b1, 12, 32'h0000_0ABC, 32'h0000_0F0F, 4, 1'b0);
    // R8 writes during busy
    bus_write(5'h04, 32'd2);
    run_cmd("meddle R8", 1, 1'b1, 24, 32'h00AB_CDEF, 32'h0011_2233, 2, 1'b1);
    bus_read(5'h10, v); check("R8 txd unchanged", v, 32'h00AB_CDEF);
    // R9 empty commands
    rises = 0;
    bus_write(5'h14, 32'h9400_0000);
    bus_read(5'h14, v); check("R9 zero count not busy", {31'd0, v[31]}, 32'd0);
    bus_write(5'h14, 32'h8400_0008);
    bus_read(5'h14, v); check("R9 no select not busy", {31'd0, v[31]}, 32'd0);
    repeat (10) @(negedge clk);
    check("R9 no sck edges", 32'(rises), 32'd0);
    check("R9 cs unchanged", {29'd0, cs_n}, 32'd7);
    bus_read(5'h18, v); check("R9 din kept", v, 32'h0011_2233);
    // R10 static pin levels
    bus_write(5'h08, 32'h0003_0101);
    check("R10 pin levels", {28'd0, cs_n, sck}, {28'd0, 3'b011, 1'b1});
    check("R10 mosi level", {31'd0, mosi}, 32'd1);
    bus_write(5'h08, 32'h0007_0000);
    check("R10 restored", {28'd0, cs_n, sck}, {28'd0, 3'b111, 1'b0});

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule